// File: doc/BRIEF.md
# CAN Pin-Side Loopback and Wake-Up Front End

This block sits between a CAN protocol engine and the physical transmit and receive pins. It holds a three-field configuration register that picks an internal loopback path, a wake-up detection mode and a clock-source selection. In loopback the engine hears its own transmit stream and the bus pin stays recessive, so a self test can run without disturbing the network. In normal operation the bus pin is synchronized and handed to the engine.

While the controller sleeps, the front end watches the synchronized bus line. It raises a one-cycle wake-up request in one of two ways. In the plain mode, any recessive-to-dominant edge triggers it. In the filtered mode, only a dominant level held for a minimum number of clock cycles triggers it. The configuration can only be changed while the controller is held in soft reset. The clock-select field is exported for a clock generator outside this block.

Top module: `can_pin_frontend`

## Requirements
- R1: After synchronous reset the register reads 0x00, `clk_sel_o` is 0 and `wake_o` is 0: normal operation, plain edge wake-up, external oscillator clock.
- R2: The field layout is bit 2 for loopback enable, bit 1 for filtered wake-up and bit 0 for clock select. A write with `reg_wr` high updates the fields at the clock edge only if `soft_rst` is high. Otherwise the write leaves every field unchanged.
- R3: With loopback set, `eng_rx` equals `eng_tx` in the same cycle, and `pin_rx` has no effect on `eng_rx`.
- R4: With loopback set, `pin_tx` is 1 (recessive). With loopback clear, `pin_tx` equals `eng_tx`.
- R5: With loopback clear, `eng_rx` shows `pin_rx` delayed by the two-flop synchronizer, which is two clock edges. The synchronizer resets to 1.
- R6: In plain mode with `sleep` high, `wake_o` is 1 in the cycle after the synchronized line goes from 1 to 0.
- R7: In filtered mode with `sleep` high, `wake_o` pulses once, one cycle after the synchronized line has been 0 for `MIN_PULSE` consecutive cycles. A return to 1 before that point restarts the count. A held dominant level gives no further pulses.
- R8: With `sleep` low, no wake-up is raised and the filter count is cleared. `wake_o` never stays high for two cycles in a row.
- R9: `clk_sel_o` follows bit 0 of the register. Bits above bit 2 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Current register fields, upper bits zero |
| soft_rst | input | 1 | Controller soft-reset status; unlocks writes |
| eng_tx | input | 1 | Transmit bit from the protocol engine |
| eng_rx | output | 1 | Receive bit to the protocol engine |
| pin_tx | output | 1 | Transmit pin to the transceiver |
| pin_rx | input | 1 | Receive pin from the transceiver (asynchronous) |
| sleep | input | 1 | Controller sleep state; enables wake-up detection |
| wake_o | output | 1 | One-cycle wake-up request |
| clk_sel_o | output | 1 | Clock-source select: 0 oscillator, 1 system clock |

## Verification
The assertions assume that `rst_n` is applied for at least one edge and that `soft_rst`, `reg_wr`, `sleep` and `eng_tx` are synchronous to `clk`. Only `pin_rx` may change at any time. The stimulus drives every input on the falling clock edge. It makes `pin_rx` up of random runs from 1 to 40 cycles long, so dominant pulses fall both just under and well over the filter threshold. It keeps `soft_rst` low for most cycles, so many write attempts land while the register is locked.

// File: rtl/canfe_pkg.sv
// Package: shared field layout of the front-end configuration register.
// Assumes the register is at least three bits wide; higher bits are unused.
package canfe_pkg;
    localparam int FLD_W = 3;

    // Field order (msb first) fixes the bit positions: loop=2, wfilt=1, clksel=0.
    typedef struct packed {
        logic loop;
        logic wfilt;
        logic clksel;
    } canfe_cfg_t;
endpackage

// File: rtl/canfe_cfg_reg.sv
// Module: configuration register with a soft-reset write lock.
// Assumes wr_en and soft_rst are synchronous to clk. Resets to all zeros.
module canfe_cfg_reg
    import canfe_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             soft_rst,
    output canfe_cfg_t       cfg,
    output logic [REG_W-1:0] rdata
);
    localparam int PAD_W = REG_W - FLD_W;

    canfe_cfg_t cfg_q;

    // Purpose: accept a write only while the controller is in soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (wr_en && soft_rst)
            cfg_q <= canfe_cfg_t'(wdata[FLD_W-1:0]);
    end

    // Purpose: read view, zero-padded above the defined fields.
    always_comb begin
        rdata = {{PAD_W{1'b0}}, cfg_q};
    end

    assign cfg = cfg_q;

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst |=> $stable(cfg_q)); // R2
endmodule

// File: rtl/canfe_sync.sv
// Module: multi-stage synchronizer for the asynchronous receive pin.
// Assumes the idle bus level is recessive, so every stage resets to 1.
module canfe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    // Purpose: shift the pin level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain_q <= '1;
        else
            chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/canfe_wake_det.sv
// Module: wake-up detector with two modes, either a raw falling edge or a
// dominant level held for MIN_PULSE cycles. It works on the synchronized line
// and is active only in sleep. Assumes MIN_PULSE >= 2.
module canfe_wake_det #(
    parameter int MIN_PULSE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_s,
    input  logic sleep,
    input  logic filt_en,
    output logic wake
);
    localparam int CNT_W = $clog2(MIN_PULSE + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MIN_PULSE - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(MIN_PULSE);

    logic             rx_prev_q;
    logic [CNT_W-1:0] cnt_q;
    logic             wake_q;
    logic             edge_hit;
    logic             pulse_hit;

    // Purpose: remember the previous line level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_prev_q <= 1'b1;
        else
            rx_prev_q <= rx_s;
    end

    // Purpose: count consecutive dominant cycles; saturate at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n || !sleep || !filt_en || rx_s)
            cnt_q <= '0;
        else if (cnt_q != CNT_FULL)
            cnt_q <= cnt_q + 1'b1;
    end

    // Purpose: decode a trigger in either mode.
    always_comb begin
        edge_hit  = rx_prev_q && !rx_s;
        pulse_hit = !rx_s && (cnt_q == CNT_LAST);
    end

    // Purpose: register a single-cycle wake request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wake_q <= 1'b0;
        else
            wake_q <= sleep && (filt_en ? pulse_hit : edge_hit);
    end

    assign wake = wake_q;

    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |=> !wake_q); // R8
    AST_WAKE_IN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |-> $past(sleep)); // R8
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_FULL); // R7
    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sleep) |-> cnt_q == '0); // R8
endmodule

// File: rtl/can_pin_frontend.sv
// Module: top of the CAN pin-side front end. It steers the loopback path,
// synchronizes the receive pin, detects wake-up and exports the clock select.
// Assumes every input except pin_rx is synchronous to clk. No clock muxing here.
module can_pin_frontend
    import canfe_pkg::*;
#(
    parameter int REG_W       = 8,
    parameter int MIN_PULSE   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             soft_rst,
    input  logic             eng_tx,
    output logic             eng_rx,
    output logic             pin_tx,
    input  logic             pin_rx,
    input  logic             sleep,
    output logic             wake_o,
    output logic             clk_sel_o
);
    canfe_cfg_t cfg;
    logic       rx_sync;

    canfe_cfg_reg #(.REG_W(REG_W)) i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .wdata    (reg_wdata),
        .soft_rst (soft_rst),
        .cfg      (cfg),
        .rdata    (reg_rdata)
    );

    canfe_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_rx),
        .q     (rx_sync)
    );

    canfe_wake_det #(.MIN_PULSE(MIN_PULSE)) i_wake (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_s    (rx_sync),
        .sleep   (sleep),
        .filt_en (cfg.wfilt),
        .wake    (wake_o)
    );

    // Purpose: route the bit streams for loopback or normal operation.
    always_comb begin
        if (cfg.loop) begin
            eng_rx = eng_tx;
            pin_tx = 1'b1;
        end else begin
            eng_rx = rx_sync;
            pin_tx = eng_tx;
        end
    end

    assign clk_sel_o = cfg.clksel;

    AST_WAKE_AFTER_DOM: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> !$past(rx_sync)); // R6
    AST_CLKSEL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst |=> $stable(clk_sel_o)); // R9
endmodule

// File: tb/test_can_pin_frontend.sv
`timescale 1ns/1ps
module test_can_pin_frontend;
    localparam int REG_W = 8;
    localparam int MINP  = 16;

    logic clk = 1'b0;
    logic rst_n, reg_wr, soft_rst, eng_tx, pin_rx, sleep;
    logic [REG_W-1:0] reg_wdata, reg_rdata;
    logic eng_rx, pin_tx, wake_o, clk_sel_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Reference state, updated from the requirements.
    logic [2:0] m_cfg;
    logic m_s1, m_s2, m_prev, m_wake;
    int   m_cnt;

    always #5 clk = ~clk;

    can_pin_frontend #(.REG_W(REG_W), .MIN_PULSE(MINP), .SYNC_STAGES(2)) i_can_pin_frontend (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .soft_rst(soft_rst), .eng_tx(eng_tx),
        .eng_rx(eng_rx), .pin_tx(pin_tx), .pin_rx(pin_rx), .sleep(sleep),
        .wake_o(wake_o), .clk_sel_o(clk_sel_o)
    );

    function automatic logic exp_wake(logic slp, logic [2:0] c, logic s2,
                                      logic prev, int cnt);
        if (!slp) return 1'b0;
        if (c[1]) return !s2 && (cnt == MINP - 1);   // R7
        return prev && !s2;                          // R6
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg <= '0; m_s1 <= 1'b1; m_s2 <= 1'b1; m_prev <= 1'b1;
            m_cnt <= 0;  m_wake <= 1'b0;
        end else begin
            if (reg_wr && soft_rst) m_cfg <= reg_wdata[2:0];
            m_s1   <= pin_rx;
            m_s2   <= m_s1;
            m_prev <= m_s2;
            if (!sleep || !m_cfg[1] || m_s2) m_cnt <= 0;
            else if (m_cnt < MINP) m_cnt <= m_cnt + 1;
            m_wake <= exp_wake(sleep, m_cfg, m_s2, m_prev, m_cnt);
        end
    end

    task automatic chk(string tag, logic [REG_W-1:0] act, logic [REG_W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk("R2/R9 rdata", reg_rdata, {5'b0, m_cfg});
        chk("R9 clk_sel", {7'b0, clk_sel_o}, {7'b0, m_cfg[0]});
        chk(m_cfg[2] ? "R3 eng_rx" : "R5 eng_rx", {7'b0, eng_rx},
            {7'b0, (m_cfg[2] ? eng_tx : m_s2)});
        chk("R4 pin_tx", {7'b0, pin_tx}, {7'b0, (m_cfg[2] ? 1'b1 : eng_tx)});
        chk("R6/R7/R8 wake", {7'b0, wake_o}, {7'b0, m_wake});
    endtask

    // Sample at the falling edge, then drive the next inputs.
    task automatic step();
        @(negedge clk);
        check_all();
    endtask

    int run_left = 0;
    task automatic rand_inputs(bit allow_unlock);
        eng_tx = 1'($urandom);
        if (run_left == 0) begin
            pin_rx   = 1'($urandom);
            run_left = $urandom_range(1, 40);
        end
        run_left--;
        if ($urandom_range(0, 99) < 2) sleep = ~sleep;
        reg_wr    = ($urandom_range(0, 9) == 0);
        reg_wdata = 8'($urandom);
        soft_rst  = allow_unlock && ($urandom_range(0, 19) == 0);
    endtask

    task automatic program_cfg(logic [2:0] v);
        reg_wr = 1'b1; soft_rst = 1'b1; reg_wdata = {5'b10101, v};
        step();
        reg_wr = 1'b0; soft_rst = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd2718));
        rst_n = 1'b0; reg_wr = 0; reg_wdata = '0; soft_rst = 0;
        eng_tx = 1; pin_rx = 1; sleep = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 rdata", reg_rdata, 8'h00);
        chk("R1 clk_sel", {7'b0, clk_sel_o}, 8'h00);
        chk("R1 wake", {7'b0, wake_o}, 8'h00);

        // R2: locked write is ignored
        reg_wr = 1; reg_wdata = 8'hFF; soft_rst = 0;
        step();
        reg_wr = 0;
        step();
        chk("R2 locked write", reg_rdata, 8'h00);

        // R7: glitch one cycle short of the threshold, then a full pulse
        program_cfg(3'b010);
        sleep = 1;
        repeat (4) step();
        pin_rx = 0;
        repeat (MINP - 1) step();
        pin_rx = 1;
        repeat (4) step();
        pin_rx = 0;
        repeat (MINP + 8) step();
        pin_rx = 1;
        repeat (4) step();

        // R3: loopback ignores the pin
        program_cfg(3'b100);
        for (int i = 0; i < 20; i++) begin
            eng_tx = 1'($urandom); pin_rx = 1'($urandom);
            step();
        end

        // Random phases over every configuration
        for (int ph = 0; ph < 48; ph++) begin
            program_cfg(3'(ph));
            for (int c = 0; c < 250; c++) begin
                rand_inputs(ph % 8 == 7);
                step();
            end
            reg_wr = 0; soft_rst = 0;
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule